// File: doc/BRIEF.md
# NAND Page Program and Erase Engine

This block keeps a small NAND-style cell array in on-chip storage and carries out the array-side work that a command front end asks for. Each page is a row made of data bytes followed by a spare area. The spare area is one thirty-second of the page size. The front end issues one of four requests: copy part of a page into its I/O buffer (load), merge buffered bytes into a page (program), wipe an aligned group of pages (erase), or record a column offset to be applied by the next load or program.

Data moves one byte per cycle over a byte-wide buffer port. For a load, the engine writes into the buffer. For a program, it reads from the buffer, and the buffer returns each byte one cycle after the read strobe. A program can only clear bits, because it ANDs each buffered byte into the stored byte. Only an erase sets bytes back to 0xFF. After reset the engine sweeps the whole array to 0xFF before it accepts its first request. Each request ends with a single-cycle done pulse, and the reported length is valid during that pulse.

Top module: `nand_pgm_engine`

## Requirements
- R1: After reset the engine writes 0xFF to every data and spare byte, and keeps req_ready low during this sweep. Afterwards every byte of every page loads as 0xFF.
- R2: A row is PAGE_BYTES data bytes followed by PAGE_BYTES/32 spare bytes, addressed by columns 0 to ROW-1. Writing spare columns of one page leaves the next page untouched.
- R3: A program stores the AND of the old byte and the buffered byte, so a bit that is 0 stays 0.
- R4: A program starts at column req_col plus the pending offset and writes min(req_len, ROW-start) bytes, taken from buffer addresses 0 upward. done_len equals that count. Accepting any load or program clears the pending offset.
- R5: Op code 3 stores req_col as the pending offset and completes with done_len 0.
- R6: An erase (op code 2) aligns the page down to a multiple of 2^ERASE_SHIFT pages and sets all data and spare bytes of those pages to 0xFF. done_len is the block's byte count.
- R7: A load, program or erase whose page index is NUM_PAGES or more changes nothing and completes with done_len 0.
- R8: A load (op code 0) with start column (req_col plus pending offset) above ROW returns length 0. Otherwise it returns ROW minus start and writes that many array bytes to buffer addresses 0, 1, 2 and so on.
- R9: Op code 1 is program. A request is taken in a cycle where req_valid and req_ready are both high. busy stays high from the next cycle until done. done lasts one cycle. req_ready stays low while busy, so a request held during an operation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_op | input | 2 | 0 load, 1 program, 2 erase, 3 set offset |
| req_page | input | PG_W | Page index, wide enough to name pages past the end |
| req_col | input | COL_W | Start column, or the offset for op 3 |
| req_len | input | COL_W | Number of buffered bytes for a program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_len | output | LEN_W | Bytes moved or erased, valid with done |
| buf_re | output | 1 | Buffer read strobe, data due next cycle |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | BUF_AW | Buffer byte address |
| buf_wdata | output | 8 | Byte written to the buffer |
| buf_rdata | input | 8 | Byte read from the buffer |

## Verification
The properties assume two things about the environment: the buffer returns read data exactly one cycle after buf_re, and req_valid holds any value while req_ready is low without that being a fault. The bench drives requests only on falling edges and keeps each request steady until it sees req_ready. It drops req_valid in the cycle after acceptance, except in the hold-off test, where it keeps a request pending for the whole of an erase on purpose. Buffer contents are changed only while the engine is idle, so a program never reads a byte that is being written at the same time.

// File: rtl/nand_pgm_pkg.sv
package nand_pgm_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_PROG   = 2'd1,
        OP_ERASE  = 2'd2,
        OP_SETOFS = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_LOAD,
        ST_PRD,
        ST_PWR,
        ST_ERASE,
        ST_DONE
    } state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    function automatic int spare_of(int page_bytes);
        return page_bytes / 32;
    endfunction

    function automatic int row_of(int page_bytes);
        return page_bytes + spare_of(page_bytes);
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nand_cell_array.sv
module nand_cell_array #(
    parameter int DEPTH = 2112,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(addr) < DEPTH)) begin
            cells[addr] <= wr_data;
        end
    end

    // out-of-range indices never occur in use; return erased value there
    assign rd_data = (int'(addr) < DEPTH) ? cells[addr] : 8'hFF;
endmodule

// File: rtl/nand_req_decode.sv
module nand_req_decode
    import nand_pgm_pkg::*;
#(
    parameter int NUM_PAGES   = 32,
    parameter int ROW         = 66,
    parameter int ERASE_SHIFT = 4,
    parameter int PG_W        = 6,
    parameter int COL_W       = 7,
    parameter int AW          = 12,
    parameter int LEN_W       = 11
) (
    input  op_e              op,
    input  logic [PG_W-1:0]  page,
    input  logic [COL_W-1:0] col,
    input  logic [COL_W-1:0] len,
    input  logic [COL_W-1:0] pend,
    output logic [AW-1:0]    start_addr,
    output logic [LEN_W-1:0] count
);
    localparam int BLK_PAGES = 1 << ERASE_SHIFT;
    localparam int BLK_BYTES = BLK_PAGES * ROW;

    int  pidx;
    int  start_col;
    int  room;
    int  base;
    int  n;
    logic in_range;

    always_comb begin
        pidx      = int'(page);
        in_range  = (pidx < NUM_PAGES);
        start_col = int'(col) + int'(pend);
        room      = (start_col >= ROW) ? 0 : (ROW - start_col);
        base      = (in_range ? pidx : 0) * ROW;
        n         = 0;
        case (op)
            OP_LOAD: n = room;
            OP_PROG: n = (int'(len) < room) ? int'(len) : room;
            OP_ERASE: begin
                n         = BLK_BYTES;
                base      = ((in_range ? pidx : 0) >> ERASE_SHIFT) * BLK_PAGES * ROW;
                start_col = 0;
            end
            default: n = 0;
        endcase
        if (!in_range) begin
            n = 0;
        end
        start_addr = AW'(base + ((start_col < ROW) ? start_col : 0));
        count      = LEN_W'(n);
    end
endmodule

// File: rtl/nand_op_fsm.sv
module nand_op_fsm
    import nand_pgm_pkg::*;
#(
    parameter int TOTAL  = 2112,
    parameter int COL_W  = 7,
    parameter int AW     = 12,
    parameter int LEN_W  = 11,
    parameter int BUF_AW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  op_e               req_op,
    input  logic [COL_W-1:0]  req_col,
    input  logic [AW-1:0]     dec_addr,
    input  logic [LEN_W-1:0]  dec_cnt,
    input  logic [7:0]        arr_rdata,
    input  logic [7:0]        buf_rdata,
    output logic              req_ready,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  done_len,
    output logic [COL_W-1:0]  pend,
    output logic              arr_we,
    output logic [AW-1:0]     arr_addr,
    output logic [7:0]        arr_wdata,
    output logic              buf_re,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata
);
    state_e            state;
    logic [AW-1:0]     cur;
    logic [LEN_W-1:0]  cnt;
    logic [BUF_AW-1:0] idx;
    logic [LEN_W-1:0]  res;
    logic              last;

    assign last = (cnt == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_INIT;
            cur   <= '0;
            cnt   <= '0;
            idx   <= '0;
            res   <= '0;
            pend  <= '0;
        end else begin
            case (state)
                ST_INIT: begin
                    if (cur == AW'(TOTAL - 1)) begin
                        cur   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cur <= cur + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (req_valid) begin
                        cur <= dec_addr;
                        cnt <= dec_cnt;
                        res <= dec_cnt;
                        idx <= '0;
                        if (req_op == OP_SETOFS) begin
                            pend <= req_col;
                        end else if (req_op != OP_ERASE) begin
                            pend <= '0;
                        end
                        if (dec_cnt == '0) begin
                            state <= ST_DONE;
                        end else begin
                            case (req_op)
                                OP_LOAD: state <= ST_LOAD;
                                OP_PROG: state <= ST_PRD;
                                default: state <= ST_ERASE;
                            endcase
                        end
                    end
                end
                ST_PRD: state <= ST_PWR;
                ST_LOAD, ST_PWR, ST_ERASE: begin
                    cur <= cur + 1'b1;
                    idx <= idx + 1'b1;
                    cnt <= cnt - 1'b1;
                    if (last) begin
                        state <= ST_DONE;
                    end else if (state == ST_PWR) begin
                        state <= ST_PRD;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        busy      = (state != ST_IDLE) && (state != ST_INIT);
        done      = (state == ST_DONE);
        done_len  = res;
        arr_addr  = cur;
        arr_we    = (state == ST_INIT) || (state == ST_ERASE) || (state == ST_PWR);
        arr_wdata = (state == ST_PWR) ? (arr_rdata & buf_rdata) : ERASED_BYTE;
        buf_we    = (state == ST_LOAD);
        buf_re    = (state == ST_PRD);
        buf_addr  = idx;
        buf_wdata = arr_rdata;
    end
endmodule

// File: rtl/nand_pgm_engine.sv
module nand_pgm_engine
    import nand_pgm_pkg::*;
#(
    parameter int  PAGE_BYTES  = 64,
    parameter int  NUM_PAGES   = 32,
    parameter int  ERASE_SHIFT = 4,
    localparam int ROW         = row_of(PAGE_BYTES),
    localparam int TOTAL       = NUM_PAGES * ROW,
    localparam int BLK_BYTES   = (1 << ERASE_SHIFT) * ROW,
    localparam int PG_W        = $clog2(NUM_PAGES) + 1,
    localparam int COL_W       = $clog2(ROW + 1),
    localparam int AW          = $clog2(TOTAL),
    localparam int LEN_W       = $clog2(max_of(BLK_BYTES, ROW) + 1),
    localparam int BUF_AW      = $clog2(ROW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [PG_W-1:0]   req_page,
    input  logic [COL_W-1:0]  req_col,
    input  logic [COL_W-1:0]  req_len,
    output logic              busy,
    output logic              done,
    output logic [LEN_W-1:0]  done_len,
    output logic              buf_re,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata
);
    op_e              op_in;
    logic [AW-1:0]    dec_addr;
    logic [LEN_W-1:0] dec_cnt;
    logic [COL_W-1:0] pend;
    logic             arr_we;
    logic [AW-1:0]    arr_addr;
    logic [7:0]       arr_wdata;
    logic [7:0]       arr_rdata;

    assign op_in = op_e'(req_op);

    nand_req_decode #(
        .NUM_PAGES  (NUM_PAGES),
        .ROW        (ROW),
        .ERASE_SHIFT(ERASE_SHIFT),
        .PG_W       (PG_W),
        .COL_W      (COL_W),
        .AW         (AW),
        .LEN_W      (LEN_W)
    ) u_dec (
        .op        (op_in),
        .page      (req_page),
        .col       (req_col),
        .len       (req_len),
        .pend      (pend),
        .start_addr(dec_addr),
        .count     (dec_cnt)
    );

    nand_op_fsm #(
        .TOTAL (TOTAL),
        .COL_W (COL_W),
        .AW    (AW),
        .LEN_W (LEN_W),
        .BUF_AW(BUF_AW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_op   (op_in),
        .req_col  (req_col),
        .dec_addr (dec_addr),
        .dec_cnt  (dec_cnt),
        .arr_rdata(arr_rdata),
        .buf_rdata(buf_rdata),
        .req_ready(req_ready),
        .busy     (busy),
        .done     (done),
        .done_len (done_len),
        .pend     (pend),
        .arr_we   (arr_we),
        .arr_addr (arr_addr),
        .arr_wdata(arr_wdata),
        .buf_re   (buf_re),
        .buf_we   (buf_we),
        .buf_addr (buf_addr),
        .buf_wdata(buf_wdata)
    );

    nand_cell_array #(
        .DEPTH(TOTAL),
        .AW   (AW)
    ) u_arr (
        .clk    (clk),
        .wr_en  (arr_we),
        .addr   (arr_addr),
        .wr_data(arr_wdata),
        .rd_data(arr_rdata)
    );
endmodule

// File: rtl/nand_pgm_engine_chk.sv
module nand_pgm_engine_chk #(
    parameter int ROW       = 66,
    parameter int BLK_BYTES = 1056,
    parameter int LEN_W     = 11,
    parameter int BUF_AW    = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic              done,
    input logic [LEN_W-1:0]  done_len,
    input logic              buf_re,
    input logic              buf_we,
    input logic [BUF_AW-1:0] buf_addr
);
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    // R8
    buf_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_we && $past(buf_we)) |-> (buf_addr == $past(buf_addr) + 1'b1));

    // R2
    buf_range_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_we || buf_re) |-> (int'(buf_addr) < ROW));

    // R6
    len_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(done_len) <= ((BLK_BYTES > ROW) ? BLK_BYTES : ROW)));
endmodule

bind nand_pgm_engine nand_pgm_engine_chk #(
    .ROW      (ROW),
    .BLK_BYTES(BLK_BYTES),
    .LEN_W    (LEN_W),
    .BUF_AW   (BUF_AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .busy     (busy),
    .done     (done),
    .done_len (done_len),
    .buf_re   (buf_re),
    .buf_we   (buf_we),
    .buf_addr (buf_addr)
);

// File: tb/sim_nand_pgm_engine.sv
module sim_nand_pgm_engine;
    localparam int CLK_PERIOD = 10;
    localparam int PB     = 64;
    localparam int NP     = 32;
    localparam int ES     = 4;
    localparam int ROW    = PB + PB / 32;
    localparam int BLK    = (1 << ES) * ROW;
    localparam int PG_W   = $clog2(NP) + 1;
    localparam int COL_W  = $clog2(ROW + 1);
    localparam int LEN_W  = $clog2(((BLK > ROW) ? BLK : ROW) + 1);
    localparam int BUF_AW = $clog2(ROW);

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  page;
        logic [7:0]  col;
        logic [7:0]  len;
        logic [7:0]  seed;
        logic [15:0] exp;
    } vec_t;

    // op: 0 load, 1 program, 2 erase
    localparam vec_t VEC [13] = '{
        '{2'd0, 8'd3,  8'd0,  8'd0,  8'h00, 16'd66},
        '{2'd1, 8'd3,  8'd0,  8'd10, 8'h5A, 16'd10},
        '{2'd1, 8'd3,  8'd5,  8'd10, 8'hC3, 16'd10},
        '{2'd1, 8'd3,  8'd60, 8'd10, 8'h96, 16'd6},
        '{2'd0, 8'd3,  8'd4,  8'd0,  8'h00, 16'd62},
        '{2'd0, 8'd3,  8'd66, 8'd0,  8'h00, 16'd0},
        '{2'd0, 8'd3,  8'd67, 8'd0,  8'h00, 16'd0},
        '{2'd1, 8'd40, 8'd0,  8'd4,  8'h00, 16'd0},
        '{2'd0, 8'd40, 8'd0,  8'd0,  8'h00, 16'd0},
        '{2'd1, 8'd20, 8'd64, 8'd2,  8'h11, 16'd2},
        '{2'd2, 8'd7,  8'd0,  8'd0,  8'h00, 16'd1056},
        '{2'd2, 8'd33, 8'd0,  8'd0,  8'h00, 16'd0},
        '{2'd2, 8'd31, 8'd0,  8'd0,  8'h00, 16'd1056}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = 2'd0;
    logic [PG_W-1:0]   req_page = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [COL_W-1:0]  req_len = '0;
    logic              busy;
    logic              done;
    logic [LEN_W-1:0]  done_len;
    logic              buf_re;
    logic              buf_we;
    logic [BUF_AW-1:0] buf_addr;
    logic [7:0]        buf_wdata;
    logic [7:0]        buf_rdata = 8'h00;

    logic [7:0] bufmem [ROW];
    logic [7:0] model  [NP*ROW];
    int         pend_m = 0;
    int         checks = 0;
    int         errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_pgm_engine u0 (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_op   (req_op),
        .req_page (req_page),
        .req_col  (req_col),
        .req_len  (req_len),
        .busy     (busy),
        .done     (done),
        .done_len (done_len),
        .buf_re   (buf_re),
        .buf_we   (buf_we),
        .buf_addr (buf_addr),
        .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata)
    );

    // buffer with one-cycle read latency
    always @(posedge clk) begin
        if (buf_we) bufmem[buf_addr] <= buf_wdata;
        if (buf_re) buf_rdata <= bufmem[buf_addr];
    end

    function automatic logic [7:0] pat(logic [7:0] seed, int i);
        return 8'(int'(seed) + i * 29);
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic fill_buf(logic [7:0] seed);
        @(negedge clk);
        for (int i = 0; i < ROW; i++) bufmem[i] <= pat(seed, i);
    endtask

    task automatic run_op(int op, int page, int col, int len, output int got);
        @(negedge clk);
        req_op    = 2'(op);
        req_page  = PG_W'(page);
        req_col   = COL_W'(col);
        req_len   = COL_W'(len);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        got = int'(done_len);
    endtask

    task automatic mdl_apply(int op, int page, int col, int len, logic [7:0] seed);
        int s = col + pend_m;
        int n;
        if (op == 3) begin
            pend_m = col;
            return;
        end
        if (op != 2) pend_m = 0;
        if (page >= NP) return;
        if (op == 1) begin
            n = (s < ROW) ? ROW - s : 0;
            if (len < n) n = len;
            for (int i = 0; i < n; i++)
                model[page*ROW + s + i] = model[page*ROW + s + i] & pat(seed, i);
        end else if (op == 2) begin
            for (int i = 0; i < BLK; i++)
                model[((page >> ES) << ES)*ROW + i] = 8'hFF;
        end
    endtask

    task automatic cmp_buf(int page, int start, int n, string tag);
        int bad = -1;
        for (int i = 0; i < n; i++)
            if (bad < 0 && bufmem[i] !== model[page*ROW + start + i]) bad = i;
        if (bad < 0) chk(1'b1, tag, "buffer content", 0, 0);
        else chk(1'b0, tag, $sformatf("page %0d col %0d byte", page, start + bad),
                 int'(bufmem[bad]), int'(model[page*ROW + start + bad]));
    endtask

    task automatic verify_page(int page, string tag);
        int got;
        run_op(0, page, 0, 0, got);
        chk(got == ROW, tag, $sformatf("verify load length page %0d", page), got, ROW);
        mdl_apply(0, page, 0, 0, 8'h00);
        cmp_buf(page, 0, ROW, tag);
    endtask

    function automatic string tag_of(int op, int page);
        if (page >= NP) return "R7";
        case (op)
            0: return "R8";
            1: return "R4";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d cycles at most", 150000, 150000);
        summary();
        $finish;
    end

    initial begin
        int got;
        int holds;
        int bad;
        for (int i = 0; i < NP*ROW; i++) model[i] = 8'hFF;

        // reset and power-up sweep
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R1", "ready during init sweep", int'(req_ready), 0);
        while (!req_ready) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R9", "idle after init", int'({busy, done}), 0);
        verify_page(0, "R1");
        verify_page(NP - 1, "R1");
        run_op(0, NP - 1, PB, 0, got);
        chk(got == ROW - PB, "R2", "spare length", got, ROW - PB);
        mdl_apply(0, NP - 1, PB, 0, 8'h00);
        cmp_buf(NP - 1, PB, ROW - PB, "R1");

        // table walk
        for (int v = 0; v < 13; v++) begin
            if (VEC[v].op == 2'd1) fill_buf(VEC[v].seed);
            run_op(int'(VEC[v].op), int'(VEC[v].page), int'(VEC[v].col),
                   int'(VEC[v].len), got);
            chk(got == int'(VEC[v].exp), tag_of(int'(VEC[v].op), int'(VEC[v].page)),
                $sformatf("vector %0d length", v), got, int'(VEC[v].exp));
            mdl_apply(int'(VEC[v].op), int'(VEC[v].page), int'(VEC[v].col),
                      int'(VEC[v].len), VEC[v].seed);
            if (VEC[v].op == 2'd0 && got > 0)
                cmp_buf(int'(VEC[v].page), int'(VEC[v].col), got, "R8");
            verify_page(3, "R3");
            verify_page(20, "R6");
        end

        // pending offset
        run_op(3, 0, 10, 0, got);
        chk(got == 0, "R5", "set offset length", got, 0);
        mdl_apply(3, 0, 10, 0, 8'h00);
        fill_buf(8'h3C);
        run_op(1, 5, 2, 3, got);
        chk(got == 3, "R4", "program with offset length", got, 3);
        mdl_apply(1, 5, 2, 3, 8'h3C);
        verify_page(5, "R4");
        fill_buf(8'hE7);
        run_op(3, 0, 60, 0, got);
        mdl_apply(3, 0, 60, 0, 8'h00);
        run_op(1, 5, 0, 10, got);
        chk(got == 6, "R4", "offset program clipped at row end", got, 6);
        mdl_apply(1, 5, 0, 10, 8'hE7);
        verify_page(5, "R3");
        run_op(3, 0, 60, 0, got);
        mdl_apply(3, 0, 60, 0, 8'h00);
        run_op(0, 5, 10, 0, got);
        chk(got == 0, "R8", "load start past row end", got, 0);
        mdl_apply(0, 5, 10, 0, 8'h00);
        run_op(0, 5, 0, 0, got);
        chk(got == ROW, "R4", "offset cleared after load", got, ROW);
        mdl_apply(0, 5, 0, 0, 8'h00);
        cmp_buf(5, 0, ROW, "R4");

        // spare area placement
        fill_buf(8'h81);
        run_op(1, 21, PB, 2, got);
        chk(got == 2, "R2", "spare program length", got, 2);
        mdl_apply(1, 21, PB, 2, 8'h81);
        run_op(0, 21, PB, 0, got);
        chk(got == 2, "R2", "spare load length", got, 2);
        mdl_apply(0, 21, PB, 0, 8'h00);
        cmp_buf(21, PB, 2, "R2");
        verify_page(22, "R2");

        // hold-off while busy
        @(negedge clk);
        req_op = 2'd2; req_page = PG_W'(16); req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_op = 2'd3; req_col = COL_W'(99);
        holds = 0; bad = 0;
        while (!done) begin
            if (req_ready || !busy) bad++;
            holds++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(bad == 0 && holds > 0, "R9", "ready low during busy", bad, 0);
        chk(int'(done_len) == BLK, "R6", "erase length", int'(done_len), BLK);
        mdl_apply(2, 16, 0, 0, 8'h00);
        fill_buf(8'h0F);
        run_op(1, 1, 0, 1, got);
        chk(got == 1, "R9", "held request ignored", got, 1);
        mdl_apply(1, 1, 0, 1, 8'h0F);
        verify_page(1, "R3");
        verify_page(21, "R6");

        summary();
        $finish;
    end
endmodule